// File: doc/BRIEF.md
# Slot Payout Evaluator With Wildcard

This block turns the final symbols of three reels into a credit payout. Each reel reports a 3-bit symbol code. A wild symbol stands in for any other symbol. Single bars and triple bars may appear together in one winning line. The evaluator does not scale the result by the wager. The surrounding game logic multiplies the base payout by the bet and updates the credit balance.

Evaluation is one registered step. The game controller places the three codes on the inputs and pulses `eval_valid_i` for one clock. On the next clock `done_o` is high for one cycle and `payout_o` carries the result. The payout then holds until the next valid pulse.

Top module: `slot_payout_eval`

## Requirements
- R1: Symbol codes are lemon 0, cherry 1, bell 2, single bar 3, triple bar 4, seven 5 and wild 6. Code 7 is invalid, and any result with a 7 on any reel pays 0.
- R2: Three equal non-wild symbols pay the base value of that symbol: lemon 2, cherry 3, bell 5, single bar 7, triple bar 9, seven 10. No payout exceeds 10.
- R3: Wild substitutes for any symbol. If the non-wild symbols of a result are all the same (one wild plus two equal symbols, or two wilds plus one symbol), the result pays that symbol's base value.
- R4: Three wilds pay 10.
- R5: A result made only of single bars, triple bars and wilds, containing both bar kinds, pays 7.
- R6: Any other result pays 0. This covers results whose non-wild symbols differ and are not only the two bar kinds, for example wild, seven, lemon.
- R7: The inputs are sampled at the clock edge where `eval_valid_i` is high. `done_o` is high during the cycle after that edge and only then. During that cycle `payout_o` shows the payout of the sampled codes. Valid pulses on consecutive clocks give a new result every cycle.
- R8: While `eval_valid_i` is low, changes on the symbol inputs have no effect, and `payout_o` keeps its last value.
- R9: An active-low reset clears `payout_o` and `done_o` to 0 at once. The reset is released synchronously, two clocks after `rst_n` rises.
- R10: Over all 343 input combinations of codes 0 to 6, the payouts total 346 credits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_valid_i | input | 1 | Single-cycle strobe that samples the three symbol codes |
| sym_a_i | input | 3 | Symbol code of the first reel |
| sym_b_i | input | 3 | Symbol code of the second reel |
| sym_c_i | input | 3 | Symbol code of the third reel |
| payout_o | output | 4 | Registered base payout in credits |
| done_o | output | 1 | High for one cycle after each accepted strobe |

## Verification
Two events can fall in the same cycle: a new strobe can arrive while `done_o` is still high for the previous result. The bench provokes this with runs of strobes on consecutive clocks, each strobe with different symbols. It checks that `done_o` stays high through the run. It also checks that every cycle of the run shows the payout of the codes sampled one edge earlier, and not a stale or merged value. A second overlap is an asynchronous reset that arrives while a result is being held. The bench checks that the output drops to zero at once, without waiting for a clock edge.

// File: rtl/slot_pay_pkg.sv
package slot_pay_pkg;

  localparam int SYM_W = 3;
  localparam int PAY_W = 4;
  localparam int KINDS = 6;   // non-wild symbol kinds

  typedef enum logic [SYM_W-1:0] {
    SYM_LEMON  = 3'd0,
    SYM_CHERRY = 3'd1,
    SYM_BELL   = 3'd2,
    SYM_BAR    = 3'd3,
    SYM_TBAR   = 3'd4,
    SYM_SEVEN  = 3'd5,
    SYM_WILD   = 3'd6,
    SYM_BAD    = 3'd7
  } sym_e;

  localparam logic [PAY_W-1:0] PAY_ALL_WILD  = 4'd10;
  localparam logic [PAY_W-1:0] PAY_MIXED_BAR = 4'd7;

  // Base value of a non-wild kind, indexed by its code
  function automatic logic [PAY_W-1:0] kind_value(input logic [SYM_W-1:0] k);
    case (k)
      SYM_LEMON:  kind_value = 4'd2;
      SYM_CHERRY: kind_value = 4'd3;
      SYM_BELL:   kind_value = 4'd5;
      SYM_BAR:    kind_value = 4'd7;
      SYM_TBAR:   kind_value = 4'd9;
      SYM_SEVEN:  kind_value = 4'd10;
      default:    kind_value = 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/slot_rst_sync.sv
module slot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/slot_sym_decode.sv
module slot_sym_decode
  import slot_pay_pkg::*;
(
  input  logic [SYM_W-1:0] sym_i,
  output logic             bad_o,
  output logic [KINDS-1:0] kind_mask_o
);

  always_comb begin
    bad_o       = (sym_i == SYM_BAD);
    kind_mask_o = '0;
    for (int k = 0; k < KINDS; k++) begin
      if (sym_i == SYM_W'(k)) kind_mask_o[k] = 1'b1;
    end
  end

endmodule

// File: rtl/slot_match_resolve.sv
module slot_match_resolve
  import slot_pay_pkg::*;
#(
  parameter int LANES = 3
) (
  input  logic [LANES-1:0]            bad_i,
  input  logic [LANES-1:0][KINDS-1:0] kind_mask_i,
  output logic [PAY_W-1:0]            pay_o
);

  localparam int CNT_W = $clog2(KINDS + 1);
  localparam logic [KINDS-1:0] BAR_PAIR =
    KINDS'((1 << int'(SYM_BAR)) | (1 << int'(SYM_TBAR)));

  logic [KINDS-1:0] seen;
  logic [CNT_W-1:0] kinds_seen;
  logic [PAY_W-1:0] single_val;
  logic             any_bad;

  always_comb begin
    seen = '0;
    for (int l = 0; l < LANES; l++) begin
      seen = seen | kind_mask_i[l];
    end
    any_bad = |bad_i;
  end

  always_comb begin
    kinds_seen = '0;
    single_val = '0;
    for (int k = 0; k < KINDS; k++) begin
      if (seen[k]) begin
        kinds_seen = kinds_seen + CNT_W'(1);
        single_val = kind_value(SYM_W'(k));
      end
    end
  end

  always_comb begin
    if (any_bad) begin
      pay_o = '0;
    end else if (kinds_seen == '0) begin
      pay_o = PAY_ALL_WILD;
    end else if (kinds_seen == CNT_W'(1)) begin
      pay_o = single_val;
    end else if (seen == BAR_PAIR) begin
      pay_o = PAY_MIXED_BAR;
    end else begin
      pay_o = '0;
    end
  end

endmodule

// File: rtl/slot_payout_eval.sv
module slot_payout_eval
  import slot_pay_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             eval_valid_i,
  input  logic [SYM_W-1:0] sym_a_i,
  input  logic [SYM_W-1:0] sym_b_i,
  input  logic [SYM_W-1:0] sym_c_i,
  output logic [PAY_W-1:0] payout_o,
  output logic             done_o
);

  localparam int LANES = 3;

  logic                            rst_core_n;
  logic [LANES-1:0][SYM_W-1:0]     lane_sym;
  logic [LANES-1:0]                lane_bad;
  logic [LANES-1:0][KINDS-1:0]     lane_mask;
  logic [PAY_W-1:0]                pay_resolved;
  logic [PAY_W-1:0]                pay_d, pay_q;
  logic                            done_d, done_q;

  slot_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk_i      (clk_i),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign lane_sym[0] = sym_a_i;
  assign lane_sym[1] = sym_b_i;
  assign lane_sym[2] = sym_c_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    slot_sym_decode u_dec (
      .sym_i       (lane_sym[g]),
      .bad_o       (lane_bad[g]),
      .kind_mask_o (lane_mask[g])
    );
  end

  slot_match_resolve #(.LANES(LANES)) u_resolve (
    .bad_i       (lane_bad),
    .kind_mask_i (lane_mask),
    .pay_o       (pay_resolved)
  );

  always_comb begin
    done_d = eval_valid_i;
    pay_d  = eval_valid_i ? pay_resolved : pay_q;
  end

  always_ff @(posedge clk_i or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pay_q  <= '0;
      done_q <= 1'b0;
    end else begin
      pay_q  <= pay_d;
      done_q <= done_d;
    end
  end

  assign payout_o = pay_q;
  assign done_o   = done_q;

endmodule

// File: rtl/slot_payout_eval_chk.sv
module slot_payout_eval_chk
  import slot_pay_pkg::*;
(
  input logic             clk_i,
  input logic             rst_core_n,
  input logic             eval_valid_i,
  input logic [SYM_W-1:0] sym_a_i,
  input logic [SYM_W-1:0] sym_b_i,
  input logic [SYM_W-1:0] sym_c_i,
  input logic [PAY_W-1:0] payout_o,
  input logic             done_o
);

  a_r1_bad_code_zero: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    (eval_valid_i && (sym_a_i == SYM_BAD || sym_b_i == SYM_BAD || sym_c_i == SYM_BAD))
      |=> (payout_o == '0));

  a_r2_pay_bounded: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    payout_o <= 4'd10);

  a_r3_two_wild_take_third: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    (eval_valid_i && sym_a_i == SYM_WILD && sym_b_i == SYM_WILD && sym_c_i < SYM_WILD)
      |=> (payout_o == kind_value($past(sym_c_i))));

  a_r4_all_wild: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    (eval_valid_i && sym_a_i == SYM_WILD && sym_b_i == SYM_WILD && sym_c_i == SYM_WILD)
      |=> (payout_o == 4'd10));

  a_r7_done_after_valid: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    eval_valid_i |=> done_o);

  a_r8_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    !eval_valid_i |=> (!done_o && $stable(payout_o)));

endmodule

bind slot_payout_eval slot_payout_eval_chk u_chk (
  .clk_i        (clk_i),
  .rst_core_n   (rst_core_n),
  .eval_valid_i (eval_valid_i),
  .sym_a_i      (sym_a_i),
  .sym_b_i      (sym_b_i),
  .sym_c_i      (sym_c_i),
  .payout_o     (payout_o),
  .done_o       (done_o)
);

// File: tb/slot_payout_eval_tb_top.sv
module slot_payout_eval_tb_top;

  logic       clk_i = 1'b0;
  logic       rst_n;
  logic       eval_valid_i;
  logic [2:0] sym_a_i, sym_b_i, sym_c_i;
  logic [3:0] payout_o;
  logic       done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;   // 250 MHz

  slot_payout_eval dut_i (
    .clk_i        (clk_i),
    .rst_n        (rst_n),
    .eval_valid_i (eval_valid_i),
    .sym_a_i      (sym_a_i),
    .sym_b_i      (sym_b_i),
    .sym_c_i      (sym_c_i),
    .payout_o     (payout_o),
    .done_o       (done_o)
  );

  function automatic int base_of(int s);
    case (s)
      0: return 2;
      1: return 3;
      2: return 5;
      3: return 7;
      4: return 9;
      5: return 10;
      default: return 0;
    endcase
  endfunction

  // Reference payout, written from the requirements
  function automatic int ref_pay(int a, int b, int c);
    int s[3];
    int first;
    bit same;
    bit bars_only;
    s = '{a, b, c};
    first = -1;
    same = 1;
    bars_only = 1;
    for (int i = 0; i < 3; i++) begin
      if (s[i] == 7) return 0;                 // R1
      if (s[i] != 6) begin
        if (s[i] != 3 && s[i] != 4) bars_only = 0;
        if (first < 0) first = s[i];
        else if (s[i] != first) same = 0;
      end
    end
    if (first < 0) return 10;                  // R4
    if (same) return base_of(first);           // R2, R3
    if (bars_only) return 7;                   // R5
    return 0;                                  // R6
  endfunction

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  // Drive one strobe, then check at the following negedge
  task automatic eval_one(string req, int a, int b, int c, output int got);
    @(negedge clk_i);
    sym_a_i = 3'(a); sym_b_i = 3'(b); sym_c_i = 3'(c);
    eval_valid_i = 1'b1;
    @(negedge clk_i);
    eval_valid_i = 1'b0;
    got = int'(payout_o);
    check({req, " done"}, int'(done_o), 1);
    check(req, int'(payout_o), ref_pay(a, b, c));
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int got;
    int total;
    int held;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    eval_valid_i = 1'b0;
    sym_a_i = '0; sym_b_i = '0; sym_c_i = '0;
    repeat (3) @(negedge clk_i);
    check("R9 reset payout", int'(payout_o), 0);
    check("R9 reset done", int'(done_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk_i);

    // Directed cases
    eval_one("R2 three lemons", 0, 0, 0, got);
    eval_one("R2 three sevens", 5, 5, 5, got);
    eval_one("R2 three triple bars", 4, 4, 4, got);
    eval_one("R3 wild seven seven", 6, 5, 5, got);
    eval_one("R3 tbar wild tbar", 4, 6, 4, got);
    eval_one("R3 wild wild cherry", 6, 6, 1, got);
    eval_one("R4 three wilds", 6, 6, 6, got);
    eval_one("R5 bar tbar bar", 3, 4, 3, got);
    eval_one("R5 wild bar tbar", 6, 3, 4, got);
    eval_one("R6 wild seven lemon", 6, 5, 0, got);
    eval_one("R6 bar bar seven", 3, 3, 5, got);
    eval_one("R1 invalid code", 7, 6, 6, got);
    eval_one("R1 invalid with match", 2, 2, 7, got);

    // R8: inputs move without strobe; output must hold
    eval_one("R8 setup", 5, 5, 5, held);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      sym_a_i = 3'(i); sym_b_i = 3'(i); sym_c_i = 3'(i);
    end
    @(negedge clk_i);
    check("R8 payout held", int'(payout_o), held);
    check("R8 no done", int'(done_o), 0);

    // R7: back-to-back strobes, distinct symbols each cycle
    @(negedge clk_i);
    sym_a_i = 3'd1; sym_b_i = 3'd1; sym_c_i = 3'd1; eval_valid_i = 1'b1;
    @(negedge clk_i);
    check("R7 b2b first", int'(payout_o), 3);
    check("R7 b2b done1", int'(done_o), 1);
    sym_a_i = 3'd6; sym_b_i = 3'd4; sym_c_i = 3'd3;
    @(negedge clk_i);
    check("R7 b2b second", int'(payout_o), 7);
    check("R7 b2b done2", int'(done_o), 1);
    sym_a_i = 3'd0; sym_b_i = 3'd2; sym_c_i = 3'd6;
    @(negedge clk_i);
    eval_valid_i = 1'b0;
    check("R7 b2b third", int'(payout_o), 0);
    @(negedge clk_i);
    check("R7 done drops", int'(done_o), 0);

    // R10: exhaustive sweep of valid codes
    total = 0;
    for (int a = 0; a < 7; a++)
      for (int b = 0; b < 7; b++)
        for (int c = 0; c < 7; c++) begin
          eval_one("R10 sweep", a, b, c, got);
          total += got;
        end
    check("R10 total payout", total, 346);

    // Constrained random mix, invalid code included
    for (int n = 0; n < 300; n++) begin
      int a, b, c;
      a = int'($urandom_range(7, 0));
      b = ($urandom_range(3, 0) == 0) ? a : int'($urandom_range(6, 0));
      c = ($urandom_range(2, 0) == 0) ? 6 : int'($urandom_range(7, 0));
      eval_one("R6 random", a, b, c, got);
    end

    // R9: asynchronous reset while a result is held
    eval_one("R9 setup", 6, 6, 6, got);
    #1 rst_n = 1'b0;
    #0.5;
    check("R9 async clear payout", int'(payout_o), 0);
    check("R9 async clear done", int'(done_o), 0);
    @(negedge clk_i);
    rst_n = 1'b1;
    repeat (4) @(negedge clk_i);
    eval_one("R9 after reset", 2, 2, 2, got);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule